// File: doc/BRIEF.md
# Stream-Loss Soft-Mute Ramp

This block sits in the stereo sample path of a digital audio receiver, after the frame decoder. While the incoming stream is present, each frame's left and right samples pass straight through to the outputs, and the block keeps a copy of the most recent valid pair. When the stream-loss indication is seen on a frame strobe, the block mutes both channels together. For linear PCM it fades the held pair linearly to zero over 4096 frames. For compressed (non-PCM) payloads it outputs zero at once, because scaling coded data would produce noise.

While a fade is in progress, a hold output tells the clock-recovery logic to freeze its loop. The hold is released when the fade completes. A separate done flag shows that the outputs are parked at zero. If the stream comes back, the block returns to pass-through on the next frame, whatever mute state it was in.

The controller has four named states:
- PASS: live samples pass through.
- RAMP: the fade is in progress.
- DONE: the fade has finished and the outputs sit at zero.
- ZERO: a compressed stream was lost and the outputs were forced to zero.

The transitions, each taken only on a frame strobe, are:
- PASS→RAMP: loss seen with the PCM flag high.
- PASS→ZERO: loss seen with the PCM flag low.
- RAMP→DONE: the frame with index 4095 has been output.
- RAMP→PASS, DONE→PASS and ZERO→PASS: the stream has returned.

Top module: `loss_mute_ramp`

## Requirements
- R1: On a frame strobe with `stream_lost` low, `out_l`/`out_r` take `in_l`/`in_r` at that clock edge, and the pair is stored as the held sample.
- R2: On the first strobe with `stream_lost` high and `is_pcm` high (from PASS), the outputs equal the held pair. This is ramp frame 0.
- R3: On ramp frame k (k = 0..4095), each output equals floor(held × (4096 − k) / 4096) in 24-bit two's complement. Both channels use the same k.
- R4: `cr_hold` is high exactly while in RAMP: from the edge of ramp frame 0 until the edge of ramp frame 4095. `cr_hold` and `mute_done` are never high together.
- R5: After the ramp, `mute_done` is high, and every further strobe with `stream_lost` high outputs zero on both channels.
- R6: On a strobe with `stream_lost` high and `is_pcm` low, taken from PASS, both outputs become zero at that edge. `cr_hold` stays low and `mute_done` goes high (ZERO).
- R7: A strobe with `stream_lost` low in RAMP, DONE or ZERO passes the live samples at that edge, and `cr_hold` and `mute_done` go low.
- R8: Without `frame_stb`, the outputs, `cr_hold` and `mute_done` do not change, whatever `in_l`, `in_r`, `stream_lost` and `is_pcm` do.
- R9: A synchronous active-high `rst` clears the outputs, the held pair, the frame count, `cr_hold` and `mute_done`. A PCM loss straight after reset therefore ramps a zero pair.
- R10: `is_pcm` is only sampled on the strobe that leaves PASS. Changes to it during RAMP, DONE or ZERO have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| stream_lost | input | 1 | High while the incoming stream is absent |
| is_pcm | input | 1 | High when the payload is linear PCM |
| in_l | input | 24 | Left (subframe A) sample, two's complement |
| in_r | input | 24 | Right (subframe B) sample, two's complement |
| out_l | output | 24 | Left sample out |
| out_r | output | 24 | Right sample out |
| cr_hold | output | 1 | Hold request to clock recovery during a fade |
| mute_done | output | 1 | Outputs are parked at zero (after fade or forced) |

## Verification
Every result of this block is due at the clock edge that carries the frame strobe: the outputs, the state flags and the fade step each sit one register behind the strobe. The bench drives a strobe and its inputs after a falling edge. Its reference model takes the same inputs at the following rising edge, and the outputs are compared at the next falling edge. Cycles without a strobe are compared as well, with fresh random inputs, so any change outside a strobe edge is caught one cycle after it happens.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    typedef enum logic [1:0] {
        ST_PASS,
        ST_RAMP,
        ST_DONE,
        ST_ZERO
    } mute_st_t;

    typedef enum logic [1:0] {
        OP_KEEP,
        OP_LIVE,
        OP_RAMP,
        OP_ZERO
    } data_op_t;

endpackage

// File: rtl/lmr_fsm.sv
module lmr_fsm
    import lmr_pkg::*;
#(
    parameter int LOG2 = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            stream_lost,
    input  logic            is_pcm,
    output data_op_t        op,
    output logic [LOG2:0]   weight,
    output logic            cr_hold,
    output logic            mute_done
);

    localparam logic [LOG2:0]   FULL = {1'b1, {LOG2{1'b0}}};
    localparam logic [LOG2-1:0] LAST = '1;

    mute_st_t        state_q, state_d;
    logic [LOG2-1:0] cnt_q, cnt_d;

    // state register (R9: reset clears state and frame count)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and datapath command, evaluated only on a strobe (R8)
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op      = OP_KEEP;
        weight  = FULL - {1'b0, cnt_q};
        if (frame_stb) begin
            unique case (state_q)
                ST_PASS: begin
                    if (!stream_lost) begin
                        op = OP_LIVE;                 // R1
                    end else if (is_pcm) begin
                        op      = OP_RAMP;            // R2: frame 0, full weight
                        cnt_d   = cnt_q + 1'b1;
                        state_d = ST_RAMP;
                    end else begin
                        op      = OP_ZERO;            // R6
                        state_d = ST_ZERO;
                    end
                end
                ST_RAMP: begin
                    if (!stream_lost) begin
                        op      = OP_LIVE;            // R7
                        cnt_d   = '0;
                        state_d = ST_PASS;
                    end else begin
                        op = OP_RAMP;                 // R3
                        if (cnt_q == LAST) begin
                            cnt_d   = '0;
                            state_d = ST_DONE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DONE, ST_ZERO: begin
                    if (!stream_lost) begin
                        op      = OP_LIVE;            // R7
                        state_d = ST_PASS;
                    end else begin
                        op = OP_ZERO;                 // R5, R10
                    end
                end
                default: state_d = ST_PASS;
            endcase
        end
    end

    // state-decoded flags (R4)
    always_comb begin
        unique case (state_q)
            ST_RAMP: begin
                cr_hold   = 1'b1;
                mute_done = 1'b0;
            end
            ST_DONE, ST_ZERO: begin
                cr_hold   = 1'b0;
                mute_done = 1'b1;
            end
            default: begin
                cr_hold   = 1'b0;
                mute_done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lmr_chan.sv
module lmr_chan
    import lmr_pkg::*;
#(
    parameter int W    = 24,
    parameter int LOG2 = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  data_op_t      op,
    input  logic [LOG2:0] weight,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    localparam int PW = W + LOG2 + 2;

    logic [W-1:0]         held_q;
    logic [W-1:0]         out_q;
    logic signed [PW-1:0] a_ext, b_ext, prod, scaled;

    // held sample times remaining weight, divided by 2^LOG2 (R3)
    always_comb begin
        a_ext  = {{(PW-W){held_q[W-1]}}, held_q};
        b_ext  = {{(PW-LOG2-1){1'b0}}, weight};
        prod   = a_ext * b_ext;
        scaled = prod >>> LOG2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            out_q  <= '0;
        end else begin
            unique case (op)
                OP_LIVE: begin
                    held_q <= din;
                    out_q  <= din;
                end
                OP_RAMP: out_q <= scaled[W-1:0];
                OP_ZERO: out_q <= '0;
                default: ;
            endcase
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/loss_mute_ramp.sv
module loss_mute_ramp
    import lmr_pkg::*;
#(
    parameter int W    = 24,
    parameter int LOG2 = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_stb,
    input  logic         stream_lost,
    input  logic         is_pcm,
    input  logic [W-1:0] in_l,
    input  logic [W-1:0] in_r,
    output logic [W-1:0] out_l,
    output logic [W-1:0] out_r,
    output logic         cr_hold,
    output logic         mute_done
);

    localparam int NCH = 2;

    data_op_t      op;
    logic [LOG2:0] weight;
    logic [W-1:0]  din  [NCH];
    logic [W-1:0]  dout [NCH];

    assign din[0] = in_l;
    assign din[1] = in_r;

    lmr_fsm #(.LOG2(LOG2)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_stb   (frame_stb),
        .stream_lost (stream_lost),
        .is_pcm      (is_pcm),
        .op          (op),
        .weight      (weight),
        .cr_hold     (cr_hold),
        .mute_done   (mute_done)
    );

    // both channels step in lockstep from one command
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lmr_chan #(.W(W), .LOG2(LOG2)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .op     (op),
            .weight (weight),
            .din    (din[c]),
            .dout   (dout[c])
        );
    end

    assign out_l = dout[0];
    assign out_r = dout[1];

endmodule

// File: rtl/lmr_chk.sv
module lmr_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         frame_stb,
    input logic         stream_lost,
    input logic         is_pcm,
    input logic [W-1:0] in_l,
    input logic [W-1:0] in_r,
    input logic [W-1:0] out_l,
    input logic [W-1:0] out_r,
    input logic         cr_hold,
    input logic         mute_done
);

    p_pass_r1: assert property (@(posedge clk) disable iff (rst)
        frame_stb && !stream_lost |=>
            out_l == $past(in_l) && out_r == $past(in_r) && !cr_hold && !mute_done);

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(cr_hold && mute_done));

    p_hold_rise_r4: assert property (@(posedge clk) disable iff (rst)
        frame_stb && stream_lost && is_pcm && !cr_hold && !mute_done |=> cr_hold);

    p_parked_zero_r5: assert property (@(posedge clk) disable iff (rst)
        frame_stb && stream_lost && mute_done |=>
            out_l == '0 && out_r == '0 && mute_done && !cr_hold);

    p_forced_zero_r6: assert property (@(posedge clk) disable iff (rst)
        frame_stb && stream_lost && !is_pcm && !cr_hold && !mute_done |=>
            out_l == '0 && out_r == '0 && !cr_hold && mute_done);

    p_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(out_l) && $stable(out_r) && $stable(cr_hold) && $stable(mute_done));

endmodule

bind loss_mute_ramp lmr_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .stream_lost (stream_lost),
    .is_pcm      (is_pcm),
    .in_l        (in_l),
    .in_r        (in_r),
    .out_l       (out_l),
    .out_r       (out_r),
    .cr_hold     (cr_hold),
    .mute_done   (mute_done)
);

// File: tb/sim_loss_mute_ramp.sv
module sim_loss_mute_ramp;

    logic        clk = 1'b0;
    logic        rst, frame_stb, stream_lost, is_pcm;
    logic [23:0] in_l, in_r;
    logic [23:0] out_l, out_r;
    logic        cr_hold, mute_done;

    always #4 clk = ~clk;   // 125 MHz

    loss_mute_ramp u0 (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .stream_lost(stream_lost),
        .is_pcm(is_pcm), .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
        .cr_hold(cr_hold), .mute_done(mute_done)
    );

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    flip_phase = 0;

    // reference model: mode 0 live, 1 fading, 2 faded, 3 forced zero
    int     m_mode = 0;
    int     m_k    = 0;
    longint m_hl = 0, m_hr = 0, m_el = 0, m_er = 0;
    string  m_ev = "R9";

    function automatic longint fade(longint h, int k);
        longint p;
        p = h * longint'(4096 - k);
        return p >>> 12;
    endfunction

    task automatic model_update();
        if (rst) begin
            m_mode = 0; m_k = 0; m_hl = 0; m_hr = 0; m_el = 0; m_er = 0; m_ev = "R9";
        end else if (!frame_stb) begin
            m_ev = "R8";
        end else if (!stream_lost) begin
            m_ev = (m_mode == 0) ? "R1" : "R7";
            m_mode = 0; m_k = 0;
            m_hl = longint'($signed(in_l)); m_hr = longint'($signed(in_r));
            m_el = m_hl; m_er = m_hr;
        end else if (m_mode == 0) begin
            if (is_pcm) begin
                m_mode = 1; m_el = fade(m_hl, 0); m_er = fade(m_hr, 0); m_k = 1; m_ev = "R2";
            end else begin
                m_mode = 3; m_el = 0; m_er = 0; m_ev = "R6";
            end
        end else if (m_mode == 1) begin
            m_el = fade(m_hl, m_k); m_er = fade(m_hr, m_k);
            m_ev = flip_phase ? "R10" : "R3";
            if (m_k == 4095) begin m_mode = 2; m_k = 0; end
            else m_k = m_k + 1;
        end else begin
            m_el = 0; m_er = 0;
            m_ev = flip_phase ? "R10" : ((m_mode == 2) ? "R5" : "R6");
        end
    endtask

    task automatic compare();
        logic [23:0] xl, xr;
        logic        xh, xd;
        string       tag;
        xl = m_el[23:0]; xr = m_er[23:0];
        xh = (m_mode == 1); xd = (m_mode >= 2);
        n_cmp++;
        if (out_l !== xl || out_r !== xr || cr_hold !== xh || mute_done !== xd) begin
            n_bad++;
            tag = (!rst && (cr_hold !== xh || mute_done !== xd)) ? "R4" : m_ev;
            $display("FAIL %s t=%0t: got l=%h r=%h hold=%b done=%b exp l=%h r=%h hold=%b done=%b",
                     tag, $time, out_l, out_r, cr_hold, mute_done, xl, xr, xh, xd);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic lo, input logic pc,
                        input logic [23:0] a, input logic [23:0] b);
        rst = r; frame_stb = s; stream_lost = lo; is_pcm = pc; in_l = a; in_r = b;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    // one frame: a strobe cycle then one or two idle cycles with noise (R8)
    task automatic frame(input logic lo, input logic pc, input logic [23:0] a, input logic [23:0] b);
        step(1'b0, 1'b1, lo, pc, a, b);
        step(1'b0, 1'b0, ~lo, $urandom_range(0, 1) != 0, 24'($urandom), 24'($urandom));
        if ($urandom_range(0, 7) == 0)
            step(1'b0, 1'b0, lo, pc, 24'($urandom), 24'($urandom));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at t=%0t", $time);
        finish_run();
    end

    initial begin
        // R9: reset state, then PCM loss fades a zero pair
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 24'h123456, 24'h654321);
        for (int i = 0; i < 10; i++) frame(1'b1, 1'b1, 24'($urandom), 24'($urandom));
        // R7 return, R1 pass-through with random data
        for (int i = 0; i < 40; i++) frame(1'b0, 1'b1, 24'($urandom), 24'($urandom));
        // R2, R3, R4, R5: extreme values, full fade, PCM flag toggling (R10)
        frame(1'b0, 1'b1, 24'h800000, 24'h7FFFFF);
        flip_phase = 1;
        for (int i = 0; i < 4101; i++)
            frame(1'b1, ($urandom_range(0, 1) != 0) || i == 0, 24'($urandom), 24'($urandom));
        flip_phase = 0;
        frame(1'b0, 1'b0, 24'h000ABC, 24'hFFF000);
        // R6: compressed payload forced to zero, PCM flag toggling afterwards (R10)
        for (int i = 0; i < 5; i++) frame(1'b0, 1'b0, 24'($urandom), 24'($urandom));
        frame(1'b1, 1'b0, 24'($urandom), 24'($urandom));
        flip_phase = 1;
        for (int i = 0; i < 20; i++) frame(1'b1, $urandom_range(0, 1) != 0, 24'($urandom), 24'($urandom));
        flip_phase = 0;
        // R7: abort a fade midway
        for (int i = 0; i < 5; i++) frame(1'b0, 1'b1, 24'($urandom), 24'($urandom));
        for (int i = 0; i < 100; i++) frame(1'b1, 1'b1, 24'($urandom), 24'($urandom));
        for (int i = 0; i < 10; i++) frame(1'b0, 1'b1, 24'($urandom), 24'($urandom));
        // small values: fade truncates towards minus infinity (R3), then parked (R5)
        frame(1'b0, 1'b1, 24'hFFFFFF, 24'h000FFF);
        for (int i = 0; i < 4100; i++) frame(1'b1, 1'b1, 24'($urandom), 24'($urandom));
        for (int i = 0; i < 5; i++) frame(1'b0, 1'b1, 24'($urandom), 24'($urandom));
        // mid-run reset while fading (R9)
        for (int i = 0; i < 8; i++) frame(1'b1, 1'b1, 24'($urandom), 24'($urandom));
        step(1'b1, 1'b0, 1'b1, 1'b1, 24'($urandom), 24'($urandom));
        for (int i = 0; i < 4; i++) frame(1'b0, 1'b1, 24'($urandom), 24'($urandom));
        finish_run();
    end

endmodule